// File: doc/BRIEF.md
# Byte-Parallel CRC-16 Engine

This block keeps a running 16-bit cyclic redundancy check using the generator polynomial 0x1021. It takes up to one 8-bit byte on every clock. Bits are handled most-significant first, and no bit reversal is applied on the way in or on the way out. The next state comes from a short XOR-and-shift network that folds the whole byte in one step. There is no eight-step shift register in the datapath and no 256-entry table.

The caller can load any 16-bit starting value. A checksum can therefore be carried on across several separate byte streams: read the result, then load it back in before the next stream. The caller presents bytes with a valid strobe and reads the running value on `crc_out`. A bit-serial reference model sits in a verification-only checker bound to the top module. It is not part of the synthesised logic. It checks that each byte update matches eight polynomial steps done one at a time.

Top module: `crc16_engine`

## Requirements
- R1: While `rst` (active high, synchronous) is sampled high at a rising clock edge, `crc_out` becomes 0xFFFF after that edge.
- R2: When `load` is sampled high, `crc_out` equals `init_value` from the next cycle on.
- R3: When `load` and `byte_valid` are both high in the same cycle, the load wins and `data_in` has no effect on `crc_out`.
- R4: When `byte_valid` is high and `load` is low, `crc_out` on the next cycle equals the following computation:
  - XOR `data_in` into bits 15..8 of the old value.
  - Run eight steps. In each step, shift left by one, and XOR in 0x1021 if bit 15 was 1 before that shift.
- R5: When neither `load` nor `byte_valid` is high, `crc_out` keeps its value.
- R6: Starting from 0xFFFF, the ASCII bytes "123456789" (0x31 through 0x39) give 0x29B1.
- R7: Starting from 0x0000, the same nine bytes give 0x31C3.
- R8: A stream split in two gives the same result as the unsplit stream, when the intermediate result is loaded back between the two parts.
- R9: Bytes presented on consecutive cycles are each absorbed, one byte per clock, with no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load strobe for the start value |
| init_value | input | 16 | Start value taken on load |
| byte_valid | input | 1 | Data byte strobe |
| data_in | input | 8 | Data byte |
| crc_out | output | 16 | Running CRC value |

## Verification
The hardest case to reach is a byte folded into a register whose upper bits drive every term of the network at once. Such register states rarely arise from short fixed strings. The stimulus therefore loads random start values and feeds long random byte streams, with idle cycles and loads scattered in between. This drives each byte value against many prior states. The bench also drives load and a byte in the same cycle, and resumes a split stream from a reloaded intermediate value.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

    localparam int CRC_W  = 16;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int HI_LSB = CRC_W - BYTE_W;
    localparam logic [CRC_W-1:0] CRC_POLY  = 16'h1021;
    localparam logic [CRC_W-1:0] CRC_RESET = 16'hFFFF;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_BYTE = 2'd2
    } crc_op_e;

    typedef struct packed {
        crc_op_e op;
        crc_t    seed;
        byte_t   data;
    } crc_req_t;

    // Folds one byte into the register using the three-term network.
    function automatic crc_t crc_fold(input crc_t cur, input byte_t d);
        byte_t t;
        crc_t  hi_shift;
        crc_t  t12;
        crc_t  t5;
        crc_t  t0;
        t        = cur[CRC_W-1:HI_LSB] ^ d;
        t        = t ^ {{NIB_W{1'b0}}, t[BYTE_W-1:NIB_W]};
        hi_shift = {cur[HI_LSB-1:0], {BYTE_W{1'b0}}};
        t12      = {t[NIB_W-1:0], {(CRC_W-NIB_W){1'b0}}};
        t5       = {3'b000, t, 5'b00000};
        t0       = {{HI_LSB{1'b0}}, t};
        return hi_shift ^ t12 ^ t5 ^ t0;
    endfunction

endpackage

// File: rtl/crc16_op_decode.sv
module crc16_op_decode
    import crc16_pkg::*;
(
    input  logic     load,
    input  crc_t     init_value,
    input  logic     byte_valid,
    input  byte_t    data_in,
    output crc_req_t req
);
    always_comb begin
        req.seed = init_value;
        req.data = data_in;
        if (load)
            req.op = OP_LOAD;
        else if (byte_valid)
            req.op = OP_BYTE;
        else
            req.op = OP_HOLD;
    end
endmodule

// File: rtl/crc16_byte_net.sv
module crc16_byte_net
    import crc16_pkg::*;
(
    input  crc_t  cur,
    input  byte_t data,
    output crc_t  nxt
);
    always_comb nxt = crc_fold(cur, data);
endmodule

// File: rtl/crc16_state_reg.sv
module crc16_state_reg
    import crc16_pkg::*;
#(
    parameter crc_t RESET_VALUE = CRC_RESET
) (
    input  logic     clk,
    input  logic     rst,
    input  crc_req_t req,
    input  crc_t     folded,
    output crc_t     state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RESET_VALUE;
        end else begin
            unique case (req.op)
                OP_LOAD: state <= req.seed;
                OP_BYTE: state <= folded;
                default: state <= state;
            endcase
        end
    end
endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
    import crc16_pkg::*;
#(
    parameter logic [15:0] RESET_VALUE = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [15:0] init_value,
    input  logic        byte_valid,
    input  logic [7:0]  data_in,
    output logic [15:0] crc_out
);
    crc_req_t req;
    crc_t     state;
    crc_t     folded;

    crc16_op_decode u_dec (
        .load       (load),
        .init_value (init_value),
        .byte_valid (byte_valid),
        .data_in    (data_in),
        .req        (req)
    );

    crc16_byte_net u_net (
        .cur  (state),
        .data (req.data),
        .nxt  (folded)
    );

    crc16_state_reg #(.RESET_VALUE(RESET_VALUE)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .folded (folded),
        .state  (state)
    );

    assign crc_out = state;
endmodule

// File: rtl/crc16_engine_chk.sv
module crc16_engine_chk #(
    parameter logic [15:0] RESET_VALUE = 16'hFFFF
) (
    input logic        clk,
    input logic        rst,
    input logic        load,
    input logic [15:0] init_value,
    input logic        byte_valid,
    input logic [7:0]  data_in,
    input logic [15:0] crc_out
);
    // Bit-serial reference, verification only.
    function automatic logic [15:0] serial_ref(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int i = 0; i < 8; i++)
            r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    logic rst_q;
    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q)
            a_reset_r1: assert (crc_out == RESET_VALUE);
    end

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> crc_out == $past(init_value));

    p_load_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (load && byte_valid) |=> crc_out == $past(init_value));

    p_serial_match_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && byte_valid) |=> crc_out == serial_ref($past(crc_out), $past(data_in)));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && !byte_valid) |=> $stable(crc_out));
endmodule

bind crc16_engine crc16_engine_chk #(.RESET_VALUE(RESET_VALUE)) chk_i (.*);

// File: tb/crc16_engine_tb_top.sv
module crc16_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [15:0] init_value = 16'h0000;
    logic        byte_valid = 1'b0;
    logic [7:0]  data_in = 8'h00;
    logic [15:0] crc_out;

    int checks = 0;
    int failures = 0;
    logic [15:0] model = 16'hFFFF;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    crc16_engine dut_i (
        .clk(clk), .rst(rst), .load(load), .init_value(init_value),
        .byte_valid(byte_valid), .data_in(data_in), .crc_out(crc_out)
    );

    function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int i = 0; i < 8; i++)
            r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, expected value pushed to scoreboard.
    task automatic drive(input logic ld, input logic [15:0] iv, input logic bv,
                         input logic [7:0] d, input string tag);
        item_t it;
        @(negedge clk);
        load = ld; init_value = iv; byte_valid = bv; data_in = d;
        if (ld) model = iv;
        else if (bv) model = ref_step(model, d);
        it.exp = model;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle_wait();
        @(negedge clk);
        load = 1'b0; byte_valid = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compares after each active edge.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, crc_out, it.exp);
        end
    end

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] mid;
        logic [15:0] whole;
        // R1 reset value
        repeat (3) @(posedge clk);
        #2 check("R1 reset", crc_out, 16'hFFFF);
        @(negedge clk); rst = 1'b0;
        model = 16'hFFFF;

        // R5 hold with data toggling but no strobe
        drive(0, 16'h1234, 0, 8'hA5, "R5 hold");
        drive(0, 16'h1234, 0, 8'h5A, "R5 hold");

        // R6 check string from 0xFFFF, back-to-back bytes (R9)
        drive(1, 16'hFFFF, 0, 8'h00, "R2 load FFFF");
        for (int i = 0; i < 9; i++) drive(0, 16'h0, 1, 8'h31 + 8'(i), "R9 back-to-back");
        idle_wait();
        check("R6 string from FFFF", crc_out, 16'h29B1);

        // R7 check string from 0x0000
        drive(1, 16'h0000, 0, 8'h00, "R2 load 0000");
        for (int i = 0; i < 9; i++) drive(0, 16'h0, 1, 8'h31 + 8'(i), "R4 string bytes");
        idle_wait();
        check("R7 string from 0000", crc_out, 16'h31C3);

        // R3 load wins over byte in same cycle
        drive(1, 16'hBEEF, 1, 8'h77, "R3 load priority");
        idle_wait();
        check("R3 load priority direct", crc_out, 16'hBEEF);

        // R8 split stream with reload of intermediate value
        drive(1, 16'hFFFF, 0, 8'h00, "R2 load");
        for (int i = 0; i < 4; i++) drive(0, 16'h0, 1, 8'h31 + 8'(i), "R8 part1");
        idle_wait();
        mid = crc_out;
        drive(1, 16'h0000, 0, 8'h00, "R2 load other");
        drive(0, 16'h0, 1, 8'hC3, "R4 unrelated");
        drive(1, mid, 0, 8'h00, "R8 reload");
        for (int i = 4; i < 9; i++) drive(0, 16'h0, 1, 8'h31 + 8'(i), "R8 part2");
        idle_wait();
        whole = crc_out;
        check("R8 split equals whole", whole, 16'h29B1);

        // R4 random streams with idles and loads
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            r = $urandom_range(0, 99);
            if (r < 5)
                drive(1, 16'($urandom), 1'($urandom), 8'($urandom), "R4 rand load");
            else if (r < 15)
                drive(0, 16'($urandom), 0, 8'($urandom), "R5 rand idle");
            else
                drive(0, 16'($urandom), 1, 8'($urandom), "R4 rand byte");
        end
        idle_wait();
        check("R4 final model", crc_out, model);

        // R1 reset mid-stream
        @(negedge clk); rst = 1'b1; byte_valid = 1'b1; data_in = 8'h11;
        @(negedge clk); rst = 1'b0; byte_valid = 1'b0;
        check("R1 reset mid-stream", crc_out, 16'hFFFF);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule